// File: doc/BRIEF.md
# I2C Master Receive Clock-Hold Controller

This block sits between the receive shifter of an I2C master and the host register port. Each byte the shifter completes is placed into one or two data registers. The block then decides whether to hold the serial clock low, so that the remote transmitter is stalled until software has taken the data. The host picks the buffering depth at run time. In single-buffer operation the clock is held as soon as a byte reaches the host-visible register. In double-buffer operation the clock is held only when both the host register and the shift-side holding register are occupied.

A bypass mode gives software direct control of both bus lines through two forced-level bits. The control register read path also reports the synchronized SCL level and a bus-busy indication. Bus-busy is set by a detected START and cleared by a detected STOP. Both line outputs are open-drain pull-down enables.

Buffer state machine (`buf_state_t`):
- `BUF_EMPTY` goes to `BUF_HOST` on a byte.
- `BUF_HOST` changes as follows:
  - It goes to `BUF_BOTH` on a byte.
  - It goes to `BUF_EMPTY` on a clear.
  - It stays in `BUF_HOST` when a byte and a clear arrive together, and the new byte replaces the host register.
- `BUF_BOTH` changes as follows:
  - It goes to `BUF_HOST` on a clear, and the held byte moves up.
  - It stays in `BUF_BOTH` on a clear plus a byte.
  - It stays in `BUF_BOTH` on a byte alone, and that byte is dropped.

Bus state machine (`bus_state_t`):
- `BUS_IDLE` goes to `BUS_ACTIVE` on START.
- `BUS_ACTIVE` goes to `BUS_IDLE` on STOP.

Line drive selection (`line_drive_t`) is `DRV_HOLD` or `DRV_BYPASS`, following the bypass bit.

Top module: `i2c_rx_hold_ctrl`

## Requirements
- R1: After reset these values hold. Control readback bit 7 (mode, 0 = double, 1 = single) and bit 4 (bypass) are 0, `data_ready` is 0, and both `scl_pull` and `sda_pull` are 0.
- R2: In double mode, a byte arriving with the host register empty appears on `rx_data`, and `data_ready` is 1 in the next cycle. SCL is not held.
- R3: In double mode, a byte arriving while `data_ready` is 1 fills the holding register. `scl_pull` goes to 1 in the next cycle.
- R4: In double mode with both registers full, a clear moves the held byte to `rx_data` and keeps `data_ready` at 1. It also releases `scl_pull` in the next cycle.
- R5: In single mode (control bit 7 = 1) without bypass, `scl_pull` is 1 whenever `data_ready` is 1. Once a clear leaves no byte pending, `data_ready` and `scl_pull` both drop to 0.
- R6: With bypass (control bit 4 = 1), `scl_pull` equals the inverse of control bit 6 and `sda_pull` equals the inverse of control bit 5, whatever the buffer state.
- R7: Control readback bit 6 returns the synchronized `scl_in` level, not the written value. The delay is at most three cycles.
- R8: Control readback bit 5 becomes 1 after a START (`sda_in` falls while `scl_in` is high). It returns to 0 after a STOP (`sda_in` rises while `scl_in` is high).
- R9: A status write (`reg_sel` = 1) clears `data_ready` only when bit 0 of the data is 0. Writing 1 has no effect.
- R10: A byte arriving while both registers are full is discarded, and `rx_data` and the pending byte are unchanged.
- R11: Without bypass, `sda_pull` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One-cycle pulse: shifter completed a byte |
| byte_data | input | DATA_W | Completed byte |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 8 | Host write data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| ctrl_rdata | output | 8 | Control readback: bit7 mode, bit6 SCL level, bit5 busy, bit4 bypass |
| rx_data | output | DATA_W | Host-visible receive register |
| data_ready | output | 1 | Data-ready flag |

## Verification
A buffer state machine stuck in the wrong state shows up at the ports within one cycle of the next byte or clear. `scl_pull` either holds a transfer that should run or frees one that should stall, and `rx_data` shows the wrong byte after a clear moves the held byte up. A wrong bus state shows up on readback bit 5 within the synchronizer delay of the next START or STOP. A wrong drive selection shows up as soon as the bypass bit or a forced-level bit is written.

// File: rtl/i2c_rx_hold_pkg.sv
package i2c_rx_hold_pkg;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_HOST  = 2'd1,
        BUF_BOTH  = 2'd2
    } buf_state_t;

    typedef enum logic {
        BUS_IDLE   = 1'b0,
        BUS_ACTIVE = 1'b1
    } bus_state_t;

    typedef enum logic {
        DRV_HOLD   = 1'b0,
        DRV_BYPASS = 1'b1
    } line_drive_t;

    localparam int unsigned REG_W       = 8;
    localparam int unsigned BIT_MODE    = 7;
    localparam int unsigned BIT_FSCL    = 6;
    localparam int unsigned BIT_FSDA    = 5;
    localparam int unsigned BIT_BYPASS  = 4;
    localparam int unsigned BIT_RDY_CLR = 0;
    localparam logic        SEL_CTRL    = 1'b0;
    localparam logic        SEL_STATUS  = 1'b1;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
    import i2c_rx_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_sync,
    output logic bus_busy
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_chain;
    logic [LAST:0] sda_chain;
    logic          sda_prev;
    logic          start_det;
    logic          stop_det;
    bus_state_t    bus_q;
    bus_state_t    bus_d;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_in;
                        sda_chain[0] <= sda_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_chain[LAST];
    end

    assign scl_sync  = scl_chain[LAST];
    assign start_det = scl_chain[LAST] &&  sda_prev && !sda_chain[LAST];
    assign stop_det  = scl_chain[LAST] && !sda_prev &&  sda_chain[LAST];

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= BUS_IDLE;
        else        bus_q <= bus_d;
    end

    always_comb begin
        bus_d = bus_q;
        unique case (bus_q)
            BUS_IDLE:   if (start_det) bus_d = BUS_ACTIVE;
            BUS_ACTIVE: if (stop_det)  bus_d = BUS_IDLE;
            default:    bus_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_busy = (bus_q == BUS_ACTIVE);
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy); // R8
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !bus_busy); // R8

endmodule

// File: rtl/i2c_rx_buffer.sv
module i2c_rx_buffer
    import i2c_rx_hold_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rdy_clear,
    input  logic              single_mode,
    output logic [DATA_W-1:0] host_data,
    output logic              data_ready,
    output logic              scl_hold
);

    buf_state_t        state_q;
    buf_state_t        state_d;
    logic [DATA_W-1:0] hold_q;
    logic              load_host_byte;
    logic              load_host_hold;
    logic              load_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d        = state_q;
        load_host_byte = 1'b0;
        load_host_hold = 1'b0;
        load_hold      = 1'b0;
        unique case (state_q)
            BUF_EMPTY: begin
                if (byte_valid) begin
                    state_d        = BUF_HOST;
                    load_host_byte = 1'b1;
                end
            end
            BUF_HOST: begin
                if (byte_valid && rdy_clear) begin
                    load_host_byte = 1'b1;
                end else if (byte_valid) begin
                    state_d   = BUF_BOTH;
                    load_hold = 1'b1;
                end else if (rdy_clear) begin
                    state_d = BUF_EMPTY;
                end
            end
            BUF_BOTH: begin
                if (rdy_clear) begin
                    load_host_hold = 1'b1;
                    if (byte_valid) load_hold = 1'b1;
                    else            state_d   = BUF_HOST;
                end
            end
            default: state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_data <= '0;
            hold_q    <= '0;
        end else begin
            if (load_host_byte)      host_data <= byte_data;
            else if (load_host_hold) host_data <= hold_q;
            if (load_hold)           hold_q    <= byte_data;
        end
    end

    always_comb begin
        data_ready = (state_q != BUF_EMPTY);
        scl_hold   = single_mode ? (state_q != BUF_EMPTY) : (state_q == BUF_BOTH);
    end

    AST_FIRST_BYTE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_EMPTY && byte_valid) |=> (data_ready && host_data == $past(byte_data))); // R2
    AST_SECOND_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_HOST && byte_valid && !rdy_clear && !single_mode) |=> scl_hold); // R3
    AST_MOVE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_BOTH && rdy_clear) |=> (data_ready && host_data == $past(hold_q))); // R4
    AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_BOTH && byte_valid && !rdy_clear) |=> ($stable(host_data) && $stable(hold_q))); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_HOST && rdy_clear && !byte_valid) |=> !data_ready); // R5

endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
    import i2c_rx_hold_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             scl_sync,
    input  logic             bus_busy,
    input  logic             scl_hold,
    output logic             single_mode,
    output logic             rdy_clear,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic [REG_W-1:0] ctrl_rdata
);

    logic        force_scl_q;
    logic        force_sda_q;
    line_drive_t drive_q;
    logic        ctrl_wr;

    assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    assign rdy_clear = reg_wr && (reg_sel == SEL_STATUS) && !reg_wdata[BIT_RDY_CLR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_mode <= 1'b0;
            force_scl_q <= 1'b1;
            force_sda_q <= 1'b1;
            drive_q     <= DRV_HOLD;
        end else if (ctrl_wr) begin
            single_mode <= reg_wdata[BIT_MODE];
            force_scl_q <= reg_wdata[BIT_FSCL];
            force_sda_q <= reg_wdata[BIT_FSDA];
            drive_q     <= reg_wdata[BIT_BYPASS] ? DRV_BYPASS : DRV_HOLD;
        end
    end

    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (drive_q)
            DRV_HOLD: begin
                scl_pull = scl_hold;
                sda_pull = 1'b0;
            end
            DRV_BYPASS: begin
                scl_pull = !force_scl_q;
                sda_pull = !force_sda_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        ctrl_rdata             = '0;
        ctrl_rdata[BIT_MODE]   = single_mode;
        ctrl_rdata[BIT_FSCL]   = scl_sync;
        ctrl_rdata[BIT_FSDA]   = bus_busy;
        ctrl_rdata[BIT_BYPASS] = (drive_q == DRV_BYPASS);
    end

    AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[BIT_BYPASS]) |=> (scl_pull == !$past(reg_wdata[BIT_FSCL]))); // R6

endmodule

// File: rtl/i2c_rx_hold_ctrl.sv
module i2c_rx_hold_ctrl
    import i2c_rx_hold_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [7:0]        ctrl_rdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready
);

    logic scl_sync;
    logic bus_busy;
    logic scl_hold;
    logic single_mode;
    logic rdy_clear;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_sync (scl_sync),
        .bus_busy (bus_busy)
    );

    i2c_rx_buffer #(.DATA_W(DATA_W)) i_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .rdy_clear   (rdy_clear),
        .single_mode (single_mode),
        .host_data   (rx_data),
        .data_ready  (data_ready),
        .scl_hold    (scl_hold)
    );

    i2c_ctrl_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .scl_sync    (scl_sync),
        .bus_busy    (bus_busy),
        .scl_hold    (scl_hold),
        .single_mode (single_mode),
        .rdy_clear   (rdy_clear),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .ctrl_rdata  (ctrl_rdata)
    );

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[BIT_BYPASS] && ctrl_rdata[BIT_MODE] && data_ready) |-> scl_pull); // R5
    AST_SDA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[BIT_BYPASS] |-> !sda_pull); // R11
    AST_STATUS_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && reg_wr && reg_sel && reg_wdata[0] && !byte_valid) |=> data_ready); // R9

endmodule

// File: tb/test_i2c_rx_hold_ctrl.sv
module test_i2c_rx_hold_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic       scl_in;
    logic       sda_in;
    logic       scl_pull;
    logic       sda_pull;
    logic [7:0] ctrl_rdata;
    logic [7:0] rx_data;
    logic       data_ready;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    i2c_rx_hold_ctrl i_i2c_rx_hold_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .ctrl_rdata (ctrl_rdata),
        .rx_data    (rx_data),
        .data_ready (data_ready)
    );

    localparam logic [1:0] OP_BYTE = 2'd0;
    localparam logic [1:0] OP_CTRL = 2'd1;
    localparam logic [1:0] OP_STAT = 2'd2;

    // {op, data, exp_ready, exp_scl_pull, exp_rx, requirement}
    localparam int NVEC = 16;
    localparam logic [23:0] VECS [NVEC] = '{
        {OP_BYTE, 8'hA5, 1'b1, 1'b0, 8'hA5, 4'd2},   // R2
        {OP_BYTE, 8'h3C, 1'b1, 1'b1, 8'hA5, 4'd3},   // R3
        {OP_BYTE, 8'hFF, 1'b1, 1'b1, 8'hA5, 4'd10},  // R10
        {OP_STAT, 8'h01, 1'b1, 1'b1, 8'hA5, 4'd9},   // R9
        {OP_STAT, 8'h00, 1'b1, 1'b0, 8'h3C, 4'd4},   // R4
        {OP_STAT, 8'h00, 1'b0, 1'b0, 8'h3C, 4'd9},
        {OP_CTRL, 8'hE0, 1'b0, 1'b0, 8'h3C, 4'd5},   // R5
        {OP_BYTE, 8'h5A, 1'b1, 1'b1, 8'h5A, 4'd5},
        {OP_BYTE, 8'h77, 1'b1, 1'b1, 8'h5A, 4'd5},
        {OP_STAT, 8'h00, 1'b1, 1'b1, 8'h77, 4'd5},
        {OP_STAT, 8'h00, 1'b0, 1'b0, 8'h77, 4'd5},
        {OP_CTRL, 8'hF0, 1'b0, 1'b0, 8'h77, 4'd6},   // R6
        {OP_BYTE, 8'h11, 1'b1, 1'b0, 8'h11, 4'd6},
        {OP_CTRL, 8'hB0, 1'b1, 1'b1, 8'h11, 4'd6},
        {OP_CTRL, 8'h60, 1'b1, 1'b0, 8'h11, 4'd2},
        {OP_STAT, 8'h00, 1'b0, 1'b0, 8'h11, 4'd9}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        byte_valid = (op == OP_BYTE);
        byte_data  = d;
        reg_wr     = (op != OP_BYTE);
        reg_sel    = (op == OP_STAT);
        reg_wdata  = d;
        @(negedge clk);
        byte_valid = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        scl_in = 1'b1; sda_in = 1'b1;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(3);

        // R1 reset state
        check("R1 mode", {7'd0, ctrl_rdata[7]}, 8'd0);
        check("R1 bypass", {7'd0, ctrl_rdata[4]}, 8'd0);
        check("R1 ready", {7'd0, data_ready}, 8'd0);
        check("R1 pulls", {6'd0, scl_pull, sda_pull}, 8'd0);
        // R7 line readback
        check("R7 high", {7'd0, ctrl_rdata[6]}, 8'd1);
        @(negedge clk); scl_in = 1'b0;
        wait_clks(3);
        check("R7 low", {7'd0, ctrl_rdata[6]}, 8'd0);
        scl_in = 1'b1;
        wait_clks(3);

        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            string tag;
            e = VECS[v];
            apply(e[23:22], e[21:14]);
            tag = $sformatf("R%0d vec%0d", e[3:0], v);
            check({tag, " ready"}, {7'd0, data_ready}, {7'd0, e[13]});
            check({tag, " scl_pull"}, {7'd0, scl_pull}, {7'd0, e[12]});
            check({tag, " rx"}, rx_data, e[11:4]);
            if (e[23:22] == OP_CTRL && e[21:14] == 8'hB0)
                check("R6 sda forced", {7'd0, sda_pull}, 8'd0);
        end

        // R6 forced SDA low, then R11 off without bypass
        apply(OP_CTRL, 8'hD0);
        check("R6 sda_pull", {7'd0, sda_pull}, 8'd1);
        check("R6 scl released", {7'd0, scl_pull}, 8'd0);
        apply(OP_CTRL, 8'h40);
        check("R11 sda_pull", {7'd0, sda_pull}, 8'd0);

        // R8 START then STOP
        check("R8 idle", {7'd0, ctrl_rdata[5]}, 8'd0);
        sda_in = 1'b0;
        wait_clks(4);
        check("R8 busy", {7'd0, ctrl_rdata[5]}, 8'd1);
        sda_in = 1'b1;
        wait_clks(4);
        check("R8 free", {7'd0, ctrl_rdata[5]}, 8'd0);
        // SDA toggling while SCL low is neither START nor STOP
        scl_in = 1'b0; wait_clks(3);
        sda_in = 1'b0; wait_clks(3);
        scl_in = 1'b1; wait_clks(4);
        check("R8 no start", {7'd0, ctrl_rdata[5]}, 8'd0);
        sda_in = 1'b1; wait_clks(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule